// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

A single DMA channel moves data between memory and one peripheral. It alternates between two buffer slots, A and B, each with its own start address and byte count. Software arms a slot by setting its start bit. The channel then runs the active slot until the slot's count is used up. If the other slot is already armed, the channel switches to it without waiting for software. While one slot is draining, software refills the slot that has finished.

Each pulse on the selected peripheral request line starts one memory burst. The burst size comes from the configured width and burst length, and the last burst of a slot is cut short to the bytes that remain. A flag in the status register shows which slot is active. The status register is read at one address and changed through two others: one where writing a 1 sets a bit, one where writing a 1 clears it. An interrupt reports slot completion and memory errors.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, every register reads zero, and `irq` and `mem_req` are low.
- R2: Register offsets:
  - 0x00 is configuration and reads back as written.
  - 0x10 and 0x18 are the start addresses of slots A and B. Address bits 1:0 are stored as zero.
  - 0x14 and 0x1C are the counts of slots A and B. Only count bits 12:0 are kept.
  - 0x0C reads the status.
- R3: Status bit layout, from bit 0 upward: run, interrupt enable, error, done A, start A, done B, start B, active slot (0 means A, 1 means B).
  - A write to 0x04 sets only run, interrupt enable, start A and start B.
  - A write to 0x08 clears any of bits 6:0.
  - The active-slot bit cannot be written.
- R4: Bursts:
  - Configuration bits 7:4 pick one of 16 bits of `per_req`. Request bits not selected are ignored.
  - While run and the active slot's start bit are set, each selected request issues one memory burst.
  - The burst size in bytes is 4 times 2 if configuration bit 2 is set, times 2 if configuration bit 3 is set. The burst is capped at the bytes remaining.
- R5: Each acknowledged burst advances the slot's address by the burst size and lowers its count by the same amount.
- R6: Slot completion:
  - When a slot's count reaches zero, its done bit is set and its start bit is cleared.
  - If the other slot is armed, the active slot flips. The next burst is then issued in the cycle after the acknowledge cycle.
  - A slot armed with a count of zero completes at once, with no memory burst.
- R7: When the active slot is not armed and the other slot is, the active-slot flag moves to the other slot.
- R8: `irq` is high exactly while interrupt enable is set and at least one of error, done A or done B is set.
- R9: Clearing run stops new bursts and leaves the slot's start bit, address and count unchanged. Setting run again resumes from the same point.
- R10: An acknowledge with `mem_err` high sets error and clears run. It leaves the slot's address and count unchanged.
- R11: Writes to a slot's address or count are ignored while that slot's start bit is set.
- R12: `mem_write` equals configuration bit 0, so 1 means peripheral to memory. `per_addr` unpacks configuration bits 31:28 to address bits 31:28 and configuration bits 27:8 to address bits 21:2. All other `per_addr` bits are zero.
- R13: Once raised, `mem_req` stays high with a stable address and length until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| per_req | input | 16 | Peripheral request lines |
| per_addr | output | 32 | Unpacked peripheral address |
| mem_req | output | 1 | Memory burst request |
| mem_write | output | 1 | Burst writes memory |
| mem_addr | output | 32 | Burst start address |
| mem_len | output | 5 | Burst length in bytes |
| mem_ack | input | 1 | Burst accepted |
| mem_err | input | 1 | Error response with ack |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps every burst setting against counts around the burst size and multiples of it, plus the largest count.
- A wrong cap on the last burst would show up as extra bytes or a missing short burst.
- It checks the switch from slot A to slot B to the exact cycle. A design that waits for software, or loses the flag, would stall or reread slot A.
- Pause, error and write-protect tests read back the stored count and address. Any drift caused by a stopped or failed burst would show up there.

// File: rtl/pp_dma_chan.sv
module pp_dma_chan #(
  parameter int CNT_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [15:0] per_req,
  output logic [31:0] per_addr,
  output logic        mem_req,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [4:0]  mem_len,
  input  logic        mem_ack,
  input  logic        mem_err,
  output logic        irq
);
  localparam logic [4:0] OFS_CFG = 5'h00, OFS_SET = 5'h04, OFS_CLR = 5'h08, OFS_STAT = 5'h0C;
  localparam logic [4:0] OFS_BASE0 = 5'h10, OFS_CNT0 = 5'h14, OFS_BASE1 = 5'h18, OFS_CNT1 = 5'h1C;

  logic [31:0]            cfg_q;
  logic [1:0][31:0]       base_q;
  logic [1:0][CNT_W-1:0]  cnt_q;
  logic                   run_q, ie_q, err_q, biu_q, busy_q, req_buf_q;
  logic [1:0]             done_q, strt_q;
  logic [31:0]            req_addr_q;
  logic [4:0]             req_len_q;

  logic [4:0]       burst;
  logic [CNT_W-1:0] act_cnt, left_cnt;
  logic [4:0]       issue_len;
  logic             can_go, issue, zero_done, idle_swap, sel_req;
  logic [7:0]       stat;

  assign burst     = cfg_q[3] ? (cfg_q[2] ? 5'd16 : 5'd8) : (cfg_q[2] ? 5'd8 : 5'd4);
  assign act_cnt   = cnt_q[biu_q];
  assign issue_len = (act_cnt < CNT_W'(burst)) ? act_cnt[4:0] : burst;
  assign sel_req   = per_req[cfg_q[7:4]];
  assign can_go    = !busy_q && run_q && strt_q[biu_q];
  assign issue     = can_go && (act_cnt != '0) && sel_req;
  assign zero_done = can_go && (act_cnt == '0);
  assign idle_swap = !busy_q && !strt_q[biu_q] && strt_q[~biu_q];
  assign left_cnt  = (cnt_q[req_buf_q] > CNT_W'(req_len_q)) ?
                     cnt_q[req_buf_q] - CNT_W'(req_len_q) : '0;

  assign stat      = {biu_q, strt_q[1], done_q[1], strt_q[0], done_q[0], err_q, ie_q, run_q};
  assign irq       = ie_q & (err_q | done_q[0] | done_q[1]);
  assign per_addr  = {cfg_q[31:28], 6'b0, cfg_q[27:8], 2'b0};
  assign mem_req   = busy_q;
  assign mem_write = cfg_q[0];
  assign mem_addr  = req_addr_q;
  assign mem_len   = req_len_q;

  always_comb begin
    case (reg_addr)
      OFS_CFG:   reg_rdata = cfg_q;
      OFS_STAT:  reg_rdata = {24'b0, stat};
      OFS_BASE0: reg_rdata = base_q[0];
      OFS_CNT0:  reg_rdata = 32'(cnt_q[0]);
      OFS_BASE1: reg_rdata = base_q[1];
      OFS_CNT1:  reg_rdata = 32'(cnt_q[1]);
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; base_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; ie_q <= 1'b0; err_q <= 1'b0; biu_q <= 1'b0;
      done_q <= '0; strt_q <= '0; busy_q <= 1'b0; req_buf_q <= 1'b0;
      req_addr_q <= '0; req_len_q <= '0;
    end else begin
      if (issue) begin
        busy_q     <= 1'b1;
        req_addr_q <= base_q[biu_q];
        req_len_q  <= issue_len;
        req_buf_q  <= biu_q;
      end
      if (zero_done) begin
        done_q[biu_q] <= 1'b1;
        strt_q[biu_q] <= 1'b0;
        if (strt_q[~biu_q]) biu_q <= ~biu_q;
      end
      if (idle_swap) biu_q <= ~biu_q;
      if (busy_q && mem_ack) begin
        busy_q <= 1'b0;
        if (mem_err) begin
          err_q <= 1'b1;
          run_q <= 1'b0;
        end else begin
          base_q[req_buf_q] <= base_q[req_buf_q] + 32'(req_len_q);
          cnt_q[req_buf_q]  <= left_cnt;
          if (left_cnt == '0) begin
            done_q[req_buf_q] <= 1'b1;
            strt_q[req_buf_q] <= 1'b0;
            if (strt_q[~req_buf_q]) biu_q <= ~req_buf_q;
          end
        end
      end
      if (reg_we) begin
        case (reg_addr)
          OFS_CFG: cfg_q <= reg_wdata;
          OFS_SET: begin
            if (reg_wdata[0]) run_q     <= 1'b1;
            if (reg_wdata[1]) ie_q      <= 1'b1;
            if (reg_wdata[4]) strt_q[0] <= 1'b1;
            if (reg_wdata[6]) strt_q[1] <= 1'b1;
          end
          OFS_CLR: begin
            if (reg_wdata[0]) run_q     <= 1'b0;
            if (reg_wdata[1]) ie_q      <= 1'b0;
            if (reg_wdata[2]) err_q     <= 1'b0;
            if (reg_wdata[3]) done_q[0] <= 1'b0;
            if (reg_wdata[4]) strt_q[0] <= 1'b0;
            if (reg_wdata[5]) done_q[1] <= 1'b0;
            if (reg_wdata[6]) strt_q[1] <= 1'b0;
          end
          OFS_BASE0: if (!strt_q[0]) base_q[0] <= {reg_wdata[31:2], 2'b00};
          OFS_CNT0:  if (!strt_q[0]) cnt_q[0]  <= reg_wdata[CNT_W-1:0];
          OFS_BASE1: if (!strt_q[1]) base_q[1] <= {reg_wdata[31:2], 2'b00};
          OFS_CNT1:  if (!strt_q[1]) cnt_q[1]  <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pp_dma_chan_props.sv
module pp_dma_chan_props (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_err,
  input logic [31:0] mem_addr,
  input logic [4:0]  mem_len,
  input logic        run_q,
  input logic        biu_q
);
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len));

  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != 5'd0) && (mem_len <= 5'd16));

  assert_err_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err && !reg_we |=> !run_q);

  assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(biu_q));
endmodule

bind pp_dma_chan pp_dma_chan_props u_props (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_err(mem_err), .mem_addr(mem_addr),
  .mem_len(mem_len), .run_q(run_q), .biu_q(biu_q)
);

// File: tb/pp_dma_chan_test.sv
module pp_dma_chan_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, reg_we, mem_ack, mem_err, mem_req, mem_write, irq;
  logic [4:0]  reg_addr, mem_len;
  logic [31:0] reg_wdata, reg_rdata, per_addr, mem_addr;
  logic [15:0] per_req;

  pp_dma_chan uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc++;

  logic [31:0] log_addr [64];
  int log_len [64], log_cyc [64], ack_cyc [64];
  int nlog = 0, ack_dly = 0, err_at = -1;
  bit pend = 0;
  int wait_n = 0, cur = 0;
  logic [31:0] p_addr;
  logic [4:0]  p_len;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0; mem_err = 1'b0;
    end else if (mem_req) begin
      if (!pend) begin
        pend = 1; wait_n = ack_dly; cur = nlog; p_addr = mem_addr; p_len = mem_len;
        if (nlog < 64) begin log_addr[nlog] = mem_addr; log_len[nlog] = int'(mem_len); log_cyc[nlog] = cyc; end
        nlog++;
      end else begin
        chk("R13 held request", {mem_addr[26:0], mem_len}, {p_addr[26:0], p_len});
      end
      if (wait_n == 0) begin
        mem_ack = 1'b1; mem_err = (cur == err_at); pend = 0;
        if (cur < 64) ack_cyc[cur] = cyc;
      end else wait_n--;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_clear(input logic [31:0] mask);
    logic [31:0] v;
    for (int t = 0; t < 20000; t++) begin
      rd(5'h0C, v);
      if ((v & mask) == 0) break;
    end
  endtask

  int cl [12] = '{1, 2, 3, 4, 5, 7, 8, 15, 16, 17, 33, 100};

  task automatic run_one(input logic [31:0] cfgv, input logic [31:0] base, input int cnt);
    logic [31:0] v;
    int bb, nb, src;
    bb = (cfgv[2] ? 8 : 4) * (cfgv[3] ? 2 : 1);
    nb = (cnt + bb - 1) / bb;
    src = int'(cfgv[7:4]);
    wr(5'h08, 32'hFF); wr(5'h00, cfgv); wr(5'h10, base); wr(5'h14, cnt);
    nlog = 0;
    wr(5'h04, 32'h11);
    per_req = ~(16'h1 << src);
    repeat (10) @(negedge clk);
    chk("R4 unselected request ignored", nlog, 0);
    per_req = 16'h1 << src;
    wait_clear(32'h10);
    per_req = '0;
    repeat (3) @(negedge clk);
    chk("R4 burst count", nlog, nb);
    for (int i = 0; i < nb && i < 64; i++) begin
      chk("R4 burst length", log_len[i], ((cnt - i * bb) < bb) ? (cnt - i * bb) : bb);
      chk("R5 burst address", log_addr[i], base + i * bb);
    end
    rd(5'h14, v); chk("R5 final count", v, 0);
    rd(5'h10, v); chk("R5 final address", v, base + cnt);
    rd(5'h0C, v); chk("R6 status after slot A", v, 32'h09);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    int n0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_ack = 1'b0; mem_err = 1'b0; per_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(5'h0C, v); chk("R1 status reset", v, 0);
    rd(5'h00, v); chk("R1 config reset", v, 0);
    rd(5'h14, v); chk("R1 count reset", v, 0);
    chk("R1 irq/req reset", {irq, mem_req}, 2'b00);

    c = 32'hA5C3_96F1;
    wr(5'h00, c);
    rd(5'h00, v); chk("R2 config readback", v, c);
    chk("R12 peripheral address", per_addr, (c & 32'hF000_0000) | (((c >> 8) & 32'hFFFFF) << 2));
    chk("R12 direction", mem_write, 1'b1);
    wr(5'h00, 32'h0); #1 chk("R12 direction off", mem_write, 1'b0);
    wr(5'h18, 32'h6003); rd(5'h18, v); chk("R2 address aligned", v, 32'h6000);
    wr(5'h1C, 32'hFFFF); rd(5'h1C, v); chk("R2 count masked", v, 32'h1FFF);
    wr(5'h04, 32'hFE); rd(5'h0C, v); chk("R3 set alias", v, 32'h52);
    wr(5'h08, 32'h52); rd(5'h0C, v); chk("R3 clear alias", v, 0);

    for (int bi = 0; bi < 4; bi++)
      for (int k = 0; k < 12; k++) begin
        ack_dly = k % 3;
        run_one((((bi * 5 + k) % 16) << 4) | (bi << 2) | (k & 1), 32'h100 * (k + 1) + 32'h4000 * bi, cl[k]);
      end
    ack_dly = 0;
    run_one(32'h0C | (32'd9 << 4), 32'h8000, 32'h1FFF);

    // two slots chained, R6 / R8
    wr(5'h08, 32'hFF); wr(5'h00, 32'h20);
    wr(5'h10, 32'h1000); wr(5'h14, 8); wr(5'h18, 32'h2000); wr(5'h1C, 8);
    nlog = 0;
    wr(5'h04, 32'h53);
    per_req = 16'h4;
    wait_clear(32'h50);
    per_req = '0;
    repeat (3) @(negedge clk);
    chk("R6 chained bursts", nlog, 4);
    chk("R6 A first", log_addr[1], 32'h1004);
    chk("R6 B follows", log_addr[2], 32'h2000);
    chk("R6 no gap", log_cyc[2] - ack_cyc[1], 2);
    rd(5'h0C, v); chk("R6 both done, slot B", v, 32'hAB);
    chk("R8 irq on done", irq, 1'b1);
    wr(5'h08, 32'h28); #1 chk("R8 irq cleared", irq, 1'b0);
    wr(5'h04, 32'h84); rd(5'h0C, v); chk("R3 error/slot not settable", v, 32'h83);
    wr(5'h08, 32'h02);

    // zero-count slot B, R6
    wr(5'h1C, 0); n0 = nlog;
    wr(5'h04, 32'h40); repeat (3) @(negedge clk);
    rd(5'h0C, v); chk("R6 zero count completes", v, 32'hA1);
    chk("R6 zero count no burst", nlog, n0);
    wr(5'h08, 32'h20);

    // idle slot switch, R7
    wr(5'h10, 32'h3000); wr(5'h14, 4);
    wr(5'h04, 32'h10);
    rd(5'h0C, v); chk("R7 slot moves to A", v, 32'h11);
    nlog = 0; per_req = 16'h4;
    wait_clear(32'h10); per_req = '0;
    chk("R7 A used", log_addr[0], 32'h3000);

    // pause and resume, R9
    wr(5'h08, 32'hFF); wr(5'h00, 32'h0);
    wr(5'h10, 32'h4000); wr(5'h14, 64);
    ack_dly = 1; nlog = 0;
    wr(5'h04, 32'h11); per_req = 16'h1;
    for (int t = 0; t < 200 && nlog < 3; t++) @(negedge clk);
    wr(5'h08, 32'h03);
    repeat (5) @(negedge clk);
    n0 = nlog;
    repeat (20) @(negedge clk);
    chk("R9 no bursts while paused", nlog, n0);
    rd(5'h0C, v); chk("R9 slot kept armed", v, 32'h10);
    rd(5'h14, v); chk("R9 count kept", v, 64 - 4 * n0);
    wr(5'h04, 32'h03);
    wait_clear(32'h10); per_req = '0;
    chk("R9 resumed total", nlog, 16);
    chk("R9 resumed last address", log_addr[15], 32'h403C);

    // memory error, R10
    wr(5'h08, 32'hFF);
    wr(5'h10, 32'h5000); wr(5'h14, 16);
    ack_dly = 0; nlog = 0; err_at = 1;
    wr(5'h04, 32'h13); per_req = 16'h1;
    repeat (30) @(negedge clk);
    per_req = '0; err_at = -1;
    rd(5'h0C, v); chk("R10 error stops run", v, 32'h16);
    chk("R8 irq on error", irq, 1'b1);
    chk("R10 bursts", nlog, 2);
    rd(5'h14, v); chk("R10 count kept", v, 12);
    rd(5'h10, v); chk("R10 address kept", v, 32'h5004);

    // write protect, R11
    wr(5'h14, 5); rd(5'h14, v); chk("R11 armed count protected", v, 12);
    wr(5'h08, 32'h10);
    wr(5'h14, 5); rd(5'h14, v); chk("R11 count writable when idle", v, 5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule